// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer

This block is a single down-counter with two companion registers, A and B. A three-bit mode field and a run bit choose how they behave together. In the two reload modes the counter is decremented either on every clock or on each qualified rising edge of an external pin. Each time it wraps from zero it takes its next start value from A and B in turn, flips a waveform output, and raises the interrupt line tied to the register just used. The on and off times of the waveform are therefore set by A and B without any help from a processor. In capture mode the counter runs freely, and a chosen edge on either of two input pins latches the current count into A or B and raises that register's interrupt.

Software reaches the block through a plain synchronous write port and a combinational read port. Both use a two-bit register select: 0 is the counter, 1 is A, 2 is B and 3 is control. The control register holds the mode in bits 2:0, the run bit in bit 3 and the capture edge polarity in bit 4. Mode codes are 3'b001 for waveform, 3'b010 for event counting and 3'b011 for capture. Every other code is idle. Both pins pass through a two-stage synchroniser and an edge detector before any logic uses them.

Top module: `dual_reg_timer`

## Requirements
- R1: After synchronous reset, the counter, A, B and the control register all read 0, and the waveform output and both interrupt lines are 0.
- R2: In waveform mode (mode 3'b001) with run set, the counter decrements on every clock. When it is 0 on an active tick, it reloads from A and from B in turn, beginning with A, and the output flips. The output is therefore high for A+1 clocks and low for B+1 clocks.
- R3: A reload from A pulses irq_a high for exactly one clock, and a reload from B pulses irq_b for one clock. The two lines are never high together in a reload mode.
- R4: In either reload mode with the run bit (bit 3) cleared, the counter and the output hold their values.
- R5: In event mode (mode 3'b010) with run set, the counter changes only on rising edges of pin A. Each edge counts once, and the change is visible after the third clock edge that follows the pin change. Steady high or low levels and falling edges leave the counter alone.
- R6: In event mode, a qualified edge that finds the counter at 0 reloads it from A and B in turn, flips the output and pulses the matching interrupt, exactly as in R2 and R3.
- R7: In capture mode (mode 3'b011) the counter decrements every clock whatever the run bit. A selected edge on pin A stores the count into A and pulses irq_a. When the counter was written with V on the edge just before the pin changed, A receives V-2.
- R8: In capture mode, a selected edge on pin B stores the count into B in the same way and pulses irq_b, leaving A unchanged.
- R9: Control bit 4 picks the capture edge: 0 selects rising edges and 1 selects falling edges. An edge of the other polarity captures nothing and raises no interrupt.
- R10: Every write to the control register restarts the alternation, so the next reload comes from A.
- R11: A write to the counter takes effect on the next clock and overrides counting in that cycle. In the idle mode codes (3'b000 and 3'b100 to 3'b111) the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 A, 2 B, 3 control |
| wr_data | input | 16 | Write data; control uses bits 4:0 |
| rd_sel | input | 2 | Read target, same coding as wr_sel |
| rd_data | output | 16 | Selected register, control zero-extended |
| pin_a_in | input | 1 | Event input, and capture input for register A |
| pin_b_in | input | 1 | Capture input for register B |
| pwm_out | output | 1 | Waveform output, flipped on each reload |
| irq_a | output | 1 | One-clock request: reload from or capture into A |
| irq_b | output | 1 | One-clock request: reload from or capture into B |

## Verification
The hardest state to reach from the ports is a reload that must come from A while the alternation already points at B. It only arises when control is rewritten in the middle of a waveform period. The stimulus lets one reload from A happen, rewrites control, and then forces the counter to 0 with a direct write so that the very next tick underflows; irq_a rather than irq_b must then fire. Capture values depend on the exact synchroniser latency, so each capture run writes a known count on the edge just before the pin moves and expects that count minus two.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'b000,
        MODE_PWM   = 3'b001,
        MODE_EVENT = 3'b010,
        MODE_CAPT  = 3'b011
    } tmr_mode_e;

    // bit 4: capture on falling edge, bit 3: run, bits 2:0: mode
    typedef struct packed {
        logic      edge_fall;
        logic      run;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_A    = 2'd1,
        SEL_B    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    function automatic logic is_reload(input tmr_mode_e m);
        return (m == MODE_PWM) || (m == MODE_EVENT);
    endfunction

    function automatic logic edge_hit(input logic rise, input logic fall, input logic fall_sel);
        return fall_sel ? fall : rise;
    endfunction

endpackage

// File: rtl/dtmr_pin_sync.sv
module dtmr_pin_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-1:0], pin[i]};
        end
        assign rise[i] =  sh[STAGES-1] & ~sh[STAGES];
        assign fall[i] = ~sh[STAGES-1] &  sh[STAGES];
    end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core import dtmr_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_ctrl_t    ctrl,
    input  logic         ctrl_wr,
    input  logic         wr_cnt,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   rise,
    input  logic [1:0]   fall,
    output logic [W-1:0] cnt,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic         pwm_out,
    output logic         irq_a,
    output logic         irq_b
);
    logic phase_b;   // next reload comes from B
    logic reload_md, capt_md, tick, under, hit_a, hit_b;

    always_comb begin
        reload_md = is_reload(ctrl.mode);
        capt_md   = (ctrl.mode == MODE_CAPT);
        tick      = reload_md && ctrl.run && ((ctrl.mode == MODE_PWM) || rise[0]);
        under     = tick && (cnt == '0);
        hit_a     = capt_md && edge_hit(rise[0], fall[0], ctrl.edge_fall);
        hit_b     = capt_md && edge_hit(rise[1], fall[1], ctrl.edge_fall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            reg_a   <= '0;
            reg_b   <= '0;
            phase_b <= 1'b0;
            pwm_out <= 1'b0;
            irq_a   <= 1'b0;
            irq_b   <= 1'b0;
        end else begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
            if (under) begin
                cnt     <= phase_b ? reg_b : reg_a;
                phase_b <= ~phase_b;
                pwm_out <= ~pwm_out;
                irq_a   <= ~phase_b;
                irq_b   <= phase_b;
            end else if (tick || capt_md) begin
                cnt <= cnt - 1'b1;
            end
            if (hit_a) begin
                reg_a <= cnt;
                irq_a <= 1'b1;
            end
            if (hit_b) begin
                reg_b <= cnt;
                irq_b <= 1'b1;
            end
            if (wr_cnt)  cnt     <= wdata;
            if (wr_a)    reg_a   <= wdata;
            if (wr_b)    reg_b   <= wdata;
            if (ctrl_wr) phase_b <= 1'b0;
        end
    end

    // R2: a reload from A leaves A's value in the counter
    p_reload_value_r2: assert property (@(posedge clk) disable iff (rst)
        irq_a && $past(reload_md) && !$past(wr_cnt) |-> cnt == reg_a);

    // R2: every reload request coincides with an output flip
    p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_a || irq_b) && $past(reload_md) |-> pwm_out != $past(pwm_out));

    p_irq_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $past(reload_md) |-> !(irq_a && irq_b));

    // R4 and R11: no counting while stopped or idle
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!wr_cnt && !capt_md && !(reload_md && ctrl.run)) |-> cnt == $past(cnt));

    p_capture_a_r7: assert property (@(posedge clk) disable iff (rst)
        irq_a && $past(capt_md) && !$past(wr_a) |-> reg_a == $past(cnt));

    p_capture_b_r8: assert property (@(posedge clk) disable iff (rst)
        irq_b && $past(capt_md) && !$past(wr_b) |-> reg_b == $past(cnt));

endmodule

// File: rtl/dual_reg_timer.sv
module dual_reg_timer import dtmr_pkg::*; #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         pin_a_in,
    input  logic         pin_b_in,
    output logic         pwm_out,
    output logic         irq_a,
    output logic         irq_b
);
    tmr_ctrl_t      ctrl;
    logic           ctrl_wr, wr_cnt, wr_a, wr_b;
    logic [1:0]     rise, fall;
    logic [W-1:0]   cnt, reg_a, reg_b;
    reg_sel_e       wsel, rsel;

    always_comb begin
        wsel    = reg_sel_e'(wr_sel);
        rsel    = reg_sel_e'(rd_sel);
        wr_cnt  = wr_en && (wsel == SEL_CNT);
        wr_a    = wr_en && (wsel == SEL_A);
        wr_b    = wr_en && (wsel == SEL_B);
        ctrl_wr = wr_en && (wsel == SEL_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_wr) ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_comb begin
        unique case (rsel)
            SEL_CNT:  rd_data = cnt;
            SEL_A:    rd_data = reg_a;
            SEL_B:    rd_data = reg_b;
            SEL_CTRL: rd_data = {{(W-CTRL_W){1'b0}}, ctrl};
            default:  rd_data = '0;
        endcase
    end

    dtmr_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  ({pin_b_in, pin_a_in}),
        .rise (rise),
        .fall (fall)
    );

    dtmr_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .ctrl_wr (ctrl_wr),
        .wr_cnt  (wr_cnt),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wdata   (wr_data),
        .rise    (rise),
        .fall    (fall),
        .cnt     (cnt),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .pwm_out (pwm_out),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );
endmodule

// File: tb/tb_dual_reg_timer.sv
module tb_dual_reg_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic        pwm_out, irq_a, irq_b;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_reg_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pin_a_in(pin_a), .pin_b_in(pin_b),
        .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // call at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int v);
        rd_sel = sel;
        #1;
        v = int'(rd_data);
    endtask

    task automatic t_reset();
        int v;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reg reset", v, 0);
        end
        check("R1 pwm reset", int'(pwm_out), 0);
        check("R1 irq reset", int'(irq_a) + int'(irq_b), 0);
    endtask

    task automatic t_pwm();
        int v;
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd5);
        wr(2'd0, 16'd0);
        wr(2'd3, 16'h0009);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            check("R2 pwm level", int'(pwm_out), (k <= 4 || k == 11) ? 1 : 0);
            check("R3 irq_a pulse", int'(irq_a), (k == 1 || k == 11) ? 1 : 0);
            check("R3 irq_b pulse", int'(irq_b), (k == 5) ? 1 : 0);
        end
        rd(2'd0, v);
        check("R2 reload A value", v, 3);
    endtask

    task automatic t_restart();
        int v;
        wr(2'd3, 16'h0009);   // alternation points back to A
        wr(2'd0, 16'd0);      // R11: direct counter write
        @(negedge clk);
        check("R10 reload from A", int'(irq_a), 1);
        check("R10 no reload from B", int'(irq_b), 0);
        rd(2'd0, v);
        check("R10 counter from A", v, 3);
    endtask

    task automatic t_stop_idle();
        int v0, v1;
        logic p0;
        wr(2'd3, 16'h0001);
        rd(2'd0, v0);
        p0 = pwm_out;
        repeat (4) @(negedge clk);
        rd(2'd0, v1);
        check("R4 stopped counter holds", v1, v0);
        check("R4 stopped pwm holds", int'(pwm_out), int'(p0));
        wr(2'd3, 16'h000D);   // undefined mode 3'b101 with run set
        wr(2'd0, 16'd77);
        repeat (4) @(negedge clk);
        rd(2'd0, v1);
        check("R11 idle counter holds written value", v1, 77);
    endtask

    task automatic pulse_a(input int exp_cnt, input int exp_ia, input int exp_ib, input int exp_pwm);
        int v;
        pin_a = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        check("R5 event count", v, exp_cnt);
        check("R6 event irq_a", int'(irq_a), exp_ia);
        check("R6 event irq_b", int'(irq_b), exp_ib);
        check("R6 event pwm", int'(pwm_out), exp_pwm);
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        check("R5 high level no count", v, exp_cnt);
        pin_a = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, v);
        check("R5 falling edge no count", v, exp_cnt);
    endtask

    task automatic t_event();
        int p0;
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd1);
        wr(2'd0, 16'd0);
        wr(2'd3, 16'h000A);
        p0 = int'(pwm_out);
        pulse_a(2, 1, 0, 1 - p0);
        pulse_a(1, 0, 0, 1 - p0);
        pulse_a(0, 0, 0, 1 - p0);
        pulse_a(1, 0, 1, p0);
    endtask

    task automatic t_capture();
        int v;
        int seen;
        wr(2'd3, 16'h0003);
        wr(2'd0, 16'd1000);
        pin_a = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 capture irq_a", int'(irq_a), 1);
        rd(2'd1, v);
        check("R7 captured A", v, 998);
        rd(2'd2, v);
        check("R7 B untouched", v, 1);
        wr(2'd0, 16'd2000);
        pin_b = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 capture irq_b", int'(irq_b), 1);
        check("R8 no irq_a", int'(irq_a), 0);
        rd(2'd2, v);
        check("R8 captured B", v, 1998);
        rd(2'd1, v);
        check("R8 A untouched", v, 998);
        wr(2'd3, 16'h0013);
        wr(2'd0, 16'd500);
        pin_a = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 falling capture irq_a", int'(irq_a), 1);
        rd(2'd1, v);
        check("R9 falling captured A", v, 498);
        pin_a = 1'b1;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen += int'(irq_a);
        end
        check("R9 rising edge ignored irq", seen, 0);
        rd(2'd1, v);
        check("R9 rising edge ignored A", v, 498);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pwm();
        t_restart();
        t_stop_idle();
        t_event();
        t_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule